// File: doc/BRIEF.md
# NAND Column-Change Read Sequencer

This block sits on the host side of an asynchronous NAND bus where commands, addresses and data share one 8-bit path. It is used after a page is already held in a die's cache register. A requester hands it a 16-bit column, a byte count and, when several dies share one chip select, a row address that picks the die. The sequencer then repositions the die's read pointer and streams the requested bytes back with a valid strobe.

A column change is three write cycles: the 05h opcode, two column bytes with the low byte first, and the E0h confirm opcode. When the multi-die flag is set, an enhanced-status selection (78h plus the row bytes, then one discarded status read) comes first, so that exactly one die drives the bus afterwards. After the last write cycle the sequencer holds both strobes high for a programmable number of clocks before the first read strobe. It then issues one read pulse per byte with no further commands, because the die stays in data-output mode.

Strobe widths and the post-write wait are parameters counted in clocks. The sequence starts only once the ready/busy pin reports ready. The die may be idle or still running a background cache read at that point.

Top module: `nand_colread_seq`

## Requirements
- R1: A single-die request produces exactly four write cycles in this order: command 05h, column bits 7:0, column bits 15:8, command E0h. A command cycle has cmd_latch=1 and addr_latch=0, and an address cycle has the reverse. Every write cycle keeps bus_dout and the latch lines steady for WE_LO+WE_HI clocks, with wr_strobe_n low for the first WE_LO of them.
- R2: With req_multi=1, the column change is preceded by command 78h and then ROW_BYTES address cycles carrying req_row low byte first. After the post-write wait comes one status read cycle that raises no rd_valid.
- R3: chip_sel_n is low from the first clock of the first write cycle to the last clock of the last read cycle, and high at all other times.
- R4: After the high phase of the last write cycle before any read, exactly TWHR clocks pass with both strobes high before rd_strobe_n first goes low.
- R5: Each read cycle holds rd_strobe_n low for RE_LO clocks and then high for RE_HI clocks. The req_len data read cycles follow one another with no write cycle in between.
- R6: bus_oe is 1 exactly during write cycles and 0 during waits, read cycles and idle.
- R7: Each data byte is sampled from bus_din on the clock edge that ends the low phase of rd_strobe_n. It is shown on rd_data with rd_valid=1 for the one following clock. Byte k of a request is the die's byte at column (req_col+k) mod 65536.
- R8: busy is 1 from the clock after a request is accepted through a final clock in which done=1 and chip_sel_n=1. done is a one-clock pulse, and busy falls on the next clock.
- R9: A request is accepted only in the idle state. After acceptance the bus stays quiet (chip_sel_n=1, both strobes high) for one clock and then for as long as bus_ready is sampled low.
- R10: req_valid is ignored while busy and is ignored when req_len is 0. In neither case does any output change.
- R11: While rst is high the block is idle: busy=0, done=0, rd_valid=0, chip_sel_n=1, both strobes high, bus_oe=0, bus_dout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_col | input | 16 | Target column in the cache register |
| req_len | input | LEN_W | Number of bytes to read |
| req_multi | input | 1 | Several dies share the chip select; select one first |
| req_row | input | 8*ROW_BYTES | Row address that picks the die |
| bus_ready | input | 1 | Ready/busy pin, 1 = ready |
| chip_sel_n | output | 1 | Active-low chip select |
| cmd_latch | output | 1 | Marks a command cycle |
| addr_latch | output | 1 | Marks an address cycle |
| wr_strobe_n | output | 1 | Active-low write strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |
| bus_dout | output | 8 | Byte driven onto the shared bus |
| bus_oe | output | 1 | Host drives the shared bus |
| bus_din | input | 8 | Byte returned by the die |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Returned data byte |
| rd_valid | output | 1 | rd_data holds a new byte |

## Verification
All bus pins change on the clock edge that follows a state change, because they decode registers only. The first write strobe therefore falls one clock after the last ready sample and two clocks after acceptance when the die is ready. rd_valid comes one clock after the last low clock of each read strobe, and the post-write wait spans exactly TWHR clocks. The bench builds the expected pin vector for every clock from these counts when it issues a request. It compares that vector on the falling edge of each clock. A behavioural die model decodes the bus cycles to locate the column, so any error in byte order or opcode shows up as wrong data as well as a wrong pin.

// File: rtl/nand_colread_pkg.sv
package nand_colread_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_WR,
        S_WHR,
        S_RD,
        S_DONE
    } seq_state_e;

    typedef enum logic {
        PH_SEL,
        PH_COL
    } seq_phase_e;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
    } bus_word_t;

    localparam logic [7:0] OP_SEL_STATUS  = 8'h78;
    localparam logic [7:0] OP_COL_CHANGE  = 8'h05;
    localparam logic [7:0] OP_COL_CONFIRM = 8'hE0;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nand_step_decode.sv
module nand_step_decode
    import nand_colread_pkg::*;
#(
    parameter int ROW_BYTES = 3,
    parameter int IDX_W     = 2
) (
    input  seq_phase_e               phase,
    input  logic [IDX_W-1:0]         idx,
    input  logic [15:0]              col,
    input  logic [ROW_BYTES*8-1:0]   row,
    output bus_word_t                word,
    output logic                     last
);
    always_comb begin
        word = '0;
        last = 1'b0;
        if (phase == PH_SEL) begin
            // R2: select command, then row bytes low first
            if (idx == '0) begin
                word.is_cmd = 1'b1;
                word.val    = OP_SEL_STATUS;
            end
            for (int b = 0; b < ROW_BYTES; b++) begin
                if (idx == IDX_W'(b + 1))
                    word.val = row[8*b +: 8];
            end
            last = (idx == IDX_W'(ROW_BYTES));
        end else begin
            // R1: change opcode, column low, column high, confirm
            case (idx)
                IDX_W'(0): begin word.is_cmd = 1'b1; word.val = OP_COL_CHANGE; end
                IDX_W'(1): word.val = col[7:0];
                IDX_W'(2): word.val = col[15:8];
                default:   begin word.is_cmd = 1'b1; word.val = OP_COL_CONFIRM; end
            endcase
            last = (idx == IDX_W'(3));
        end
    end
endmodule

// File: rtl/nand_byte_capture.sv
module nand_byte_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_data,
    input  logic [7:0] din,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    // R7: sample on the edge closing the strobe low phase
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= take && take_data;
            if (take && take_data)
                rd_data <= din;
        end
    end
endmodule

// File: rtl/nand_colread_seq.sv
module nand_colread_seq
    import nand_colread_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int ROW_BYTES = 3,
    parameter int WE_LO     = 2,
    parameter int WE_HI     = 2,
    parameter int RE_LO     = 2,
    parameter int RE_HI     = 1,
    parameter int TWHR      = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [15:0]            req_col,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_multi,
    input  logic [ROW_BYTES*8-1:0] req_row,
    input  logic                   bus_ready,
    output logic                   chip_sel_n,
    output logic                   cmd_latch,
    output logic                   addr_latch,
    output logic                   wr_strobe_n,
    output logic                   rd_strobe_n,
    output logic [7:0]             bus_dout,
    output logic                   bus_oe,
    input  logic [7:0]             bus_din,
    output logic                   busy,
    output logic                   done,
    output logic [7:0]             rd_data,
    output logic                   rd_valid
);
    localparam int TMAX  = max_of(max_of(max_of(WE_LO, WE_HI), max_of(RE_LO, RE_HI)), TWHR);
    localparam int TW    = $clog2(TMAX + 1);
    localparam int IDX_W = $clog2(max_of(ROW_BYTES, 3) + 1);

    seq_state_e             st, st_n;
    seq_phase_e             ph, ph_n;
    logic [IDX_W-1:0]       idx, idx_n;
    logic                   hi_q, hi_n;
    logic                   stat_q, stat_n;
    logic [LEN_W-1:0]       remain, rem_n;
    logic [15:0]            col_q, col_n;
    logic [ROW_BYTES*8-1:0] row_q, row_n;

    logic                   t_load, t_zero;
    logic [TW-1:0]          t_val;
    logic                   take;
    bus_word_t              word;
    logic                   step_last;

    nand_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    nand_step_decode #(.ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_decode (
        .phase (ph),
        .idx   (idx),
        .col   (col_q),
        .row   (row_q),
        .word  (word),
        .last  (step_last)
    );

    nand_byte_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_data (!stat_q),
        .din       (bus_din),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    always_comb begin
        st_n   = st;
        ph_n   = ph;
        idx_n  = idx;
        hi_n   = hi_q;
        stat_n = stat_q;
        rem_n  = remain;
        col_n  = col_q;
        row_n  = row_q;
        t_load = 1'b0;
        t_val  = '0;
        take   = 1'b0;
        case (st)
            S_IDLE: begin
                // R10: zero-length requests are dropped
                if (req_valid && req_len != '0) begin
                    st_n  = S_CHK;
                    col_n = req_col;
                    row_n = req_row;
                    rem_n = req_len;
                    ph_n  = req_multi ? PH_SEL : PH_COL;
                end
            end
            S_CHK: begin
                // R9: hold off until the die reports ready
                if (bus_ready) begin
                    st_n   = S_WR;
                    idx_n  = '0;
                    hi_n   = 1'b0;
                    t_load = 1'b1;
                    t_val  = TW'(WE_LO - 1);
                end
            end
            S_WR: begin
                if (t_zero) begin
                    if (!hi_q) begin
                        hi_n   = 1'b1;
                        t_load = 1'b1;
                        t_val  = TW'(WE_HI - 1);
                    end else if (!step_last) begin
                        idx_n  = idx + IDX_W'(1);
                        hi_n   = 1'b0;
                        t_load = 1'b1;
                        t_val  = TW'(WE_LO - 1);
                    end else begin
                        st_n   = S_WHR;
                        stat_n = (ph == PH_SEL);
                        t_load = 1'b1;
                        t_val  = TW'(TWHR - 1);
                    end
                end
            end
            S_WHR: begin
                // R4: fixed wait before the first read strobe
                if (t_zero) begin
                    st_n   = S_RD;
                    hi_n   = 1'b0;
                    t_load = 1'b1;
                    t_val  = TW'(RE_LO - 1);
                end
            end
            S_RD: begin
                if (t_zero) begin
                    if (!hi_q) begin
                        take   = 1'b1;
                        hi_n   = 1'b1;
                        t_load = 1'b1;
                        t_val  = TW'(RE_HI - 1);
                    end else if (stat_q) begin
                        stat_n = 1'b0;
                        ph_n   = PH_COL;
                        idx_n  = '0;
                        hi_n   = 1'b0;
                        st_n   = S_WR;
                        t_load = 1'b1;
                        t_val  = TW'(WE_LO - 1);
                    end else if (remain > LEN_W'(1)) begin
                        // R5: back-to-back data reads
                        rem_n  = remain - LEN_W'(1);
                        hi_n   = 1'b0;
                        t_load = 1'b1;
                        t_val  = TW'(RE_LO - 1);
                    end else begin
                        st_n = S_DONE;
                    end
                end
            end
            S_DONE:  st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ph     <= PH_COL;
            idx    <= '0;
            hi_q   <= 1'b0;
            stat_q <= 1'b0;
            remain <= '0;
            col_q  <= '0;
            row_q  <= '0;
        end else begin
            st     <= st_n;
            ph     <= ph_n;
            idx    <= idx_n;
            hi_q   <= hi_n;
            stat_q <= stat_n;
            remain <= rem_n;
            col_q  <= col_n;
            row_q  <= row_n;
        end
    end

    // R3, R6, R8: pins decode registered state only
    always_comb begin
        busy        = (st != S_IDLE);
        done        = (st == S_DONE);
        chip_sel_n  = !(st == S_WR || st == S_WHR || st == S_RD);
        cmd_latch   = (st == S_WR) && word.is_cmd;
        addr_latch  = (st == S_WR) && !word.is_cmd;
        wr_strobe_n = !((st == S_WR) && !hi_q);
        rd_strobe_n = !((st == S_RD) && !hi_q);
        bus_oe      = (st == S_WR);
        bus_dout    = (st == S_WR) ? word.val : 8'h00;
    end
endmodule

// File: rtl/nand_colread_chk.sv
module nand_colread_chk #(
    parameter int WE_HI = 2,
    parameter int TWHR  = 6
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic chip_sel_n,
    input logic cmd_latch,
    input logic addr_latch,
    input logic wr_strobe_n,
    input logic rd_strobe_n,
    input logic bus_oe,
    input logic rd_valid
);
    logic [15:0] since_we;
    logic        pend_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_we <= '0;
            pend_rd  <= 1'b0;
        end else begin
            if (!wr_strobe_n) begin
                since_we <= '0;
                pend_rd  <= 1'b1;
            end else if (since_we != 16'hFFFF) begin
                since_we <= since_we + 16'd1;
            end
            if (!rd_strobe_n)
                pend_rd <= 1'b0;
        end
    end

    assert_latch_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(cmd_latch && addr_latch));

    assert_strobe_needs_cs_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_strobe_n || !rd_strobe_n) |-> !chip_sel_n);

    assert_wait_before_read_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_rd && !rd_strobe_n) |-> (32'(since_we) >= WE_HI + TWHR));

    assert_oe_off_in_read_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe_n |-> !bus_oe);

    assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(rd_strobe_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (chip_sel_n && wr_strobe_n && rd_strobe_n && !bus_oe));
endmodule

bind nand_colread_seq nand_colread_chk #(.WE_HI(WE_HI), .TWHR(TWHR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .chip_sel_n  (chip_sel_n),
    .cmd_latch   (cmd_latch),
    .addr_latch  (addr_latch),
    .wr_strobe_n (wr_strobe_n),
    .rd_strobe_n (rd_strobe_n),
    .bus_oe      (bus_oe),
    .rd_valid    (rd_valid)
);

// File: tb/tb_nand_colread_seq.sv
module tb_nand_colread_seq;
    localparam int LEN_W = 12, ROW_BYTES = 3;
    localparam int WE_LO = 2, WE_HI = 2, RE_LO = 2, RE_HI = 1, TWHR = 6;

    typedef struct packed {
        logic busy, done, cs_n, cle, ale, we_n, re_n, oe;
        logic [7:0] io;
        logic vld;
        logic [7:0] dat;
    } exp_t;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_multi = 0, bus_ready = 1;
    logic [15:0] req_col = 0;
    logic [LEN_W-1:0] req_len = 0;
    logic [ROW_BYTES*8-1:0] req_row = 0;
    logic chip_sel_n, cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, bus_oe, busy, done, rd_valid;
    logic [7:0] bus_dout, bus_din, rd_data;

    int checks = 0, errors = 0;
    string cur_tag = "R11";
    exp_t q[$];
    bit finished = 0;

    always #2 clk = ~clk;

    nand_colread_seq #(.LEN_W(LEN_W), .ROW_BYTES(ROW_BYTES), .WE_LO(WE_LO), .WE_HI(WE_HI),
        .RE_LO(RE_LO), .RE_HI(RE_HI), .TWHR(TWHR)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_col(req_col), .req_len(req_len),
        .req_multi(req_multi), .req_row(req_row), .bus_ready(bus_ready),
        .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
        .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_valid(rd_valid));

    // behavioural die: decodes bus cycles to find its column
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    logic [15:0] ptr = 0;
    logic [7:0]  al = 0, ah = 0;
    int          acnt = 0;
    logic        stat_mode = 0;

    always @(posedge wr_strobe_n) begin
        if (cmd_latch) begin
            acnt <= 0;
            stat_mode <= (bus_dout == 8'h78);
            if (bus_dout == 8'hE0) ptr <= {ah, al};
        end else if (addr_latch) begin
            if (acnt == 0) al <= bus_dout;
            if (acnt == 1) ah <= bus_dout;
            acnt <= acnt + 1;
        end
    end
    always @(posedge rd_strobe_n) if (!stat_mode) ptr <= ptr + 16'd1;
    assign bus_din = stat_mode ? 8'hE0 : pat(ptr);

    function automatic exp_t idle_v();
        exp_t e = '0;
        e.cs_n = 1; e.we_n = 1; e.re_n = 1;
        return e;
    endfunction

    task automatic chk(input string what, input string rq, input logic [7:0] act, input logic [7:0] ex);
        if (act !== ex) begin
            errors++;
            $display("FAIL %s [%s] %s actual=%h expected=%h t=%0t", rq, cur_tag, what, act, ex, $time);
        end
    endtask

    task automatic compare();
        exp_t e = (q.size() > 0) ? q.pop_front() : idle_v();
        checks++;
        chk("busy", "R8", 8'(busy), 8'(e.busy));
        chk("done", "R8", 8'(done), 8'(e.done));
        chk("chip_sel_n", "R3", 8'(chip_sel_n), 8'(e.cs_n));
        chk("cmd_latch", "R1", 8'(cmd_latch), 8'(e.cle));
        chk("addr_latch", "R1", 8'(addr_latch), 8'(e.ale));
        chk("wr_strobe_n", "R1", 8'(wr_strobe_n), 8'(e.we_n));
        chk("rd_strobe_n", "R4/R5", 8'(rd_strobe_n), 8'(e.re_n));
        chk("bus_oe", "R6", 8'(bus_oe), 8'(e.oe));
        chk("bus_dout", "R1/R2", bus_dout, e.io);
        chk("rd_valid", "R7", 8'(rd_valid), 8'(e.vld));
        if (e.vld) chk("rd_data", "R7", rd_data, e.dat);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic push_chk(input int n);
        exp_t e = idle_v();
        e.busy = 1;
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic push_wr(input logic cmd, input logic [7:0] v);
        for (int i = 0; i < WE_LO + WE_HI; i++) begin
            exp_t e = idle_v();
            e.busy = 1; e.cs_n = 0; e.cle = cmd; e.ale = !cmd;
            e.we_n = (i >= WE_LO); e.oe = 1; e.io = v;
            q.push_back(e);
        end
    endtask

    task automatic push_wait();
        for (int i = 0; i < TWHR; i++) begin
            exp_t e = idle_v();
            e.busy = 1; e.cs_n = 0;
            q.push_back(e);
        end
    endtask

    task automatic push_rd(input logic is_data, input logic [7:0] d);
        for (int i = 0; i < RE_LO + RE_HI; i++) begin
            exp_t e = idle_v();
            e.busy = 1; e.cs_n = 0; e.re_n = (i >= RE_LO);
            e.vld = is_data && (i == RE_LO); e.dat = d;
            q.push_back(e);
        end
    endtask

    task automatic push_done();
        exp_t e = idle_v();
        e.busy = 1; e.done = 1;
        q.push_back(e);
    endtask

    // issue one request; bus_ready held low so that the check phase lasts h clocks
    task automatic run_req(input logic [15:0] col, input int len, input logic multi,
                           input logic [23:0] row, input int h, input bit poke);
        req_valid = 1; req_col = col; req_len = LEN_W'(len); req_multi = multi; req_row = row;
        bus_ready = (h > 1) ? 1'b0 : 1'b1;
        push_chk(h);
        if (multi) begin
            push_wr(1, 8'h78);
            for (int b = 0; b < ROW_BYTES; b++) push_wr(0, row[8*b +: 8]);
            push_wait();
            push_rd(0, 8'h00);
        end
        push_wr(1, 8'h05);
        push_wr(0, col[7:0]);
        push_wr(0, col[15:8]);
        push_wr(1, 8'hE0);
        push_wait();
        for (int k = 0; k < len; k++) push_rd(1, pat(col + 16'(k)));
        push_done();
        for (int i = 1; i <= h; i++) begin
            tick();
            if (i == 1) req_valid = 0;
            if (i == h) bus_ready = 1;
        end
        for (int i = 0; q.size() > 0; i++) begin
            tick();
            // R10: a request while busy must leave every output untouched
            if (poke && i == 4) begin
                req_valid = 1; req_col = 16'hDEAD; req_len = 2; req_multi = 1;
            end
            if (poke && i == 5) req_valid = 0;
        end
        repeat (3) tick();
    endtask

    initial begin
        // R11: reset state
        cur_tag = "R11";
        repeat (3) tick();
        rst = 0;
        repeat (2) tick();

        cur_tag = "R1";
        run_req(16'h1234, 5, 0, 24'h0, 1, 0);

        cur_tag = "R2";
        run_req(16'h00FF, 3, 1, 24'h0A0B0C, 1, 0);

        cur_tag = "R9";
        run_req(16'h4321, 2, 1, 24'h112233, 5, 0);

        cur_tag = "R10";
        run_req(16'h0F0F, 4, 0, 24'h0, 1, 1);

        // R10: zero length is dropped
        req_valid = 1; req_col = 16'h5555; req_len = 0; req_multi = 0;
        tick();
        req_valid = 0;
        repeat (6) tick();

        // R7: column wraps past the top of the register
        cur_tag = "R7";
        run_req(16'hFFFE, 4, 0, 24'h0, 2, 0);

        cur_tag = "R5";
        run_req(16'h8001, 8, 1, 24'hC0FFEE, 1, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule